// File: doc/BRIEF.md
# Card command issue unit

This unit turns one command write into a single transaction with a memory card. A write carries an 11-bit command word and a 32-bit argument. When the word asks for it, the unit offers the card a request with a 6-bit command index and the argument. It then waits for the card's reply, which is a byte count and up to sixteen reply bytes. The reply is judged against the kind of answer the command asked for. Good replies are packed into four 32-bit response words. The outcome of every issued command is shown on three result flags.

The command port is valid/ready and accepts one write only while the unit is idle. A writer that is refused keeps its word and argument steady with valid held high until ready is seen. The request towards the card is held valid, with index and argument unchanged, until the card accepts it. The unit then raises ready on the reply channel and takes the first reply offered. There is no other back-pressure, and nothing is queued inside the unit. Line signalling and checksum work belong to neighbouring logic.

Top module: `card_cmd_issuer`

## Requirements
- R1: A command word holds the index in bits [5:0], "answer wanted" in bit 6, "long answer" in bit 7, two mode bits (8 and 9) that are stored but change nothing, and "go" in bit 10. An accepted word is stored whole and shown on `cmd_q`.
- R2: A write whose bit 10 is clear only updates the stored word. It raises no request, does not make the unit busy, and leaves the result flags and response words unchanged.
- R3: After a write with bit 10 set, `req_valid` rises with `req_index` = word[5:0] and `req_arg` = the written argument. These hold steady until `req_ready` is seen.
- R4: If an answer is wanted and the reply length is 0, or is 4 for a long-answer command, or is anything other than 4 or 16, `sts_timeout` is set and the response words keep their old values.
- R5: Reply byte n sits at `rsp_data[8n+7:8n]`. Bytes are packed big-endian, so byte 4k lands in bits [31:24] of response word k, and byte 4k+3 lands in bits [7:0]. Word k is shown at `resp_words[32k+31:32k]`.
- R6: A good short reply (length 4, or 16 for a short-answer command) loads word 0 and clears words 1 to 3.
- R7: A good long reply (length 16) loads all four words, with bit 0 of word 3 forced to 0.
- R8: A good reply sets `sts_resp_end`. A command that wants no answer sets `sts_cmd_sent` whatever length comes back, and leaves the response words alone.
- R9: When an issued command completes, by any outcome, bit 10 of the stored word is cleared and the other bits are kept.
- R10: `cmd_active` is high from the cycle after a write with bit 10 set is accepted until the reply handshake. While it is high, `cmd_ready` is low, and a waiting write takes effect only after completion.
- R11: Accepting a write with bit 10 set clears all three result flags. After completion, exactly one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command write offered |
| cmd_ready | output | 1 | Unit idle; write taken on valid and ready |
| cmd_word | input | 11 | Command word (see R1) |
| cmd_arg | input | 32 | Command argument |
| req_valid | output | 1 | Request offered to the card |
| req_ready | input | 1 | Card accepts the request |
| req_index | output | 6 | Command index of the request |
| req_arg | output | 32 | Argument of the request |
| rsp_valid | input | 1 | Card reply offered |
| rsp_ready | output | 1 | Unit waiting for a reply |
| rsp_len | input | 5 | Reply length in bytes |
| rsp_data | input | 128 | Reply bytes, byte n at [8n+7:8n] |
| cmd_q | output | 11 | Stored command word |
| resp_words | output | 128 | Response words, word k at [32k+31:32k] |
| sts_cmd_sent | output | 1 | Last issued command wanted no answer |
| sts_resp_end | output | 1 | Last issued command got a good reply |
| sts_timeout | output | 1 | Last issued command got a bad or missing reply |
| cmd_active | output | 1 | A command is in flight |

## Verification
The completion of one command and the acceptance of the next write can fall on neighbouring edges. The flags of the first must be visible for a cycle, and the second must clear them on its own acceptance. To provoke this, a second write is raised and held valid while the first is still in flight. The scoreboard then compares the first command's stored word, flags and response words in the completion cycle. The driver checks, in the following cycle, that the second write was taken, that the unit is busy again and that all flags are clear. Timeouts of every kind are placed after good replies, so that response words kept from before can be told apart from freshly loaded ones.

// File: rtl/cmdu_pkg.sv
package cmdu_pkg;
  localparam int CW_W   = 11;
  localparam int IDX_W  = 6;
  localparam int B_WANT = 6;
  localparam int B_LONG = 7;
  localparam int B_GO   = 10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } cmdu_state_e;

  typedef struct packed {
    logic timeout;
    logic resp_end;
    logic cmd_sent;
  } cmdu_result_t;
endpackage

// File: rtl/cmdu_fsm.sv
module cmdu_fsm
  import cmdu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_go,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic cmd_ready,
  output logic req_valid,
  output logic rsp_ready,
  output logic busy
);
  cmdu_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cmd_valid && cmd_go) state_d = ST_ISSUE;
      ST_ISSUE: if (req_ready)           state_d = ST_WAIT;
      ST_WAIT:  if (rsp_valid)           state_d = ST_IDLE;
      default:                           state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign req_valid = (state_q == ST_ISSUE);
  assign rsp_ready = (state_q == ST_WAIT);
  assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/cmdu_resp_eval.sv
module cmdu_resp_eval
  import cmdu_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  parameter int LEN_W   = 5
) (
  input  logic                      want,
  input  logic                      long_rsp,
  input  logic [LEN_W-1:0]          len,
  input  logic [N_WORDS*WORD_W-1:0] data,
  output cmdu_result_t              result,
  output logic [N_WORDS*WORD_W-1:0] words
);
  localparam int BPW       = WORD_W / 8;
  localparam int NBYTES    = N_WORDS * BPW;
  localparam int SHORT_LEN = BPW;
  localparam int LONG_LEN  = NBYTES;

  logic [N_WORDS*WORD_W-1:0] packed_be;
  logic                      bad_len;

  for (genvar gw = 0; gw < N_WORDS; gw++) begin : g_word
    for (genvar gb = 0; gb < BPW; gb++) begin : g_byte
      assign packed_be[gw*WORD_W + WORD_W - 1 - 8*gb -: 8] = data[(gw*BPW + gb)*8 +: 8];
    end
    if (gw == 0) begin : g_first
      assign words[WORD_W-1:0] = packed_be[WORD_W-1:0];
    end else if (gw == N_WORDS - 1) begin : g_last
      assign words[gw*WORD_W +: WORD_W] =
        long_rsp ? (packed_be[gw*WORD_W +: WORD_W] & ~WORD_W'(1)) : '0;
    end else begin : g_mid
      assign words[gw*WORD_W +: WORD_W] =
        long_rsp ? packed_be[gw*WORD_W +: WORD_W] : '0;
    end
  end

  assign bad_len = (len == '0)
                || (len == LEN_W'(SHORT_LEN) && long_rsp)
                || (len != LEN_W'(SHORT_LEN) && len != LEN_W'(LONG_LEN));

  always_comb begin
    result = '0;
    if (!want)        result.cmd_sent = 1'b1;
    else if (bad_len) result.timeout  = 1'b1;
    else              result.resp_end = 1'b1;
  end
endmodule

// File: rtl/cmdu_resp_bank.sv
module cmdu_resp_bank #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [N_WORDS*WORD_W-1:0] load_words,
  output logic [N_WORDS*WORD_W-1:0] words_q
);
  for (genvar gw = 0; gw < N_WORDS; gw++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)    words_q[gw*WORD_W +: WORD_W] <= '0;
      else if (load) words_q[gw*WORD_W +: WORD_W] <= load_words[gw*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/card_cmd_issuer.sv
module card_cmd_issuer
  import cmdu_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  parameter int LEN_W   = 5,
  parameter int ARG_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [CW_W-1:0]           cmd_word,
  input  logic [ARG_W-1:0]          cmd_arg,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic [IDX_W-1:0]          req_index,
  output logic [ARG_W-1:0]          req_arg,
  input  logic                      rsp_valid,
  output logic                      rsp_ready,
  input  logic [LEN_W-1:0]          rsp_len,
  input  logic [N_WORDS*WORD_W-1:0] rsp_data,
  output logic [CW_W-1:0]           cmd_q,
  output logic [N_WORDS*WORD_W-1:0] resp_words,
  output logic                      sts_cmd_sent,
  output logic                      sts_resp_end,
  output logic                      sts_timeout,
  output logic                      cmd_active
);
  logic                      cmd_fire, rsp_fire;
  logic [ARG_W-1:0]          arg_q;
  cmdu_result_t              res_d, res_q;
  logic [N_WORDS*WORD_W-1:0] words_d;

  cmdu_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_go    (cmd_word[B_GO]),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .cmd_ready (cmd_ready),
    .req_valid (req_valid),
    .rsp_ready (rsp_ready),
    .busy      (cmd_active)
  );

  assign cmd_fire = cmd_valid && cmd_ready;
  assign rsp_fire = rsp_valid && rsp_ready;

  cmdu_resp_eval #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .LEN_W(LEN_W)) u_eval (
    .want     (cmd_q[B_WANT]),
    .long_rsp (cmd_q[B_LONG]),
    .len      (rsp_len),
    .data     (rsp_data),
    .result   (res_d),
    .words    (words_d)
  );

  cmdu_resp_bank #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (rsp_fire && res_d.resp_end),
    .load_words (words_d),
    .words_q    (resp_words)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      arg_q <= '0;
      res_q <= '0;
    end else begin
      if (cmd_fire) begin
        cmd_q <= cmd_word;
        arg_q <= cmd_arg;
        if (cmd_word[B_GO]) res_q <= '0;
      end
      if (rsp_fire) begin
        cmd_q[B_GO] <= 1'b0;
        res_q       <= res_d;
      end
    end
  end

  assign req_index    = cmd_q[IDX_W-1:0];
  assign req_arg      = arg_q;
  assign sts_cmd_sent = res_q.cmd_sent;
  assign sts_resp_end = res_q.resp_end;
  assign sts_timeout  = res_q.timeout;
endmodule

// File: rtl/card_cmd_issuer_chk.sv
module card_cmd_issuer_chk #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  parameter int ARG_W   = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cmd_valid,
  input logic                      cmd_ready,
  input logic                      cmd_word_go,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic [5:0]                req_index,
  input logic [ARG_W-1:0]          req_arg,
  input logic                      cmd_q_go,
  input logic [N_WORDS*WORD_W-1:0] resp_words,
  input logic                      sts_cmd_sent,
  input logic                      sts_resp_end,
  input logic                      sts_timeout,
  input logic                      cmd_active
);
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_index) && $stable(req_arg));

  a_r10_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_active |-> !cmd_ready);

  a_r11_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sts_timeout, sts_resp_end, sts_cmd_sent}));

  a_r9_go_cleared_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_active |-> !cmd_q_go);

  a_r4_timeout_keeps_words: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_timeout) |-> $stable(resp_words));

  a_r7_last_lsb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    resp_words[(N_WORDS-1)*WORD_W] == 1'b0);

  a_r2_no_go_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !cmd_word_go |=> !cmd_active && !req_valid);
endmodule

bind card_cmd_issuer card_cmd_issuer_chk #(
  .WORD_W(WORD_W), .N_WORDS(N_WORDS), .ARG_W(ARG_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_word_go  (cmd_word[cmdu_pkg::B_GO]),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_index    (req_index),
  .req_arg      (req_arg),
  .cmd_q_go     (cmd_q[cmdu_pkg::B_GO]),
  .resp_words   (resp_words),
  .sts_cmd_sent (sts_cmd_sent),
  .sts_resp_end (sts_resp_end),
  .sts_timeout  (sts_timeout),
  .cmd_active   (cmd_active)
);

// File: tb/card_cmd_issuer_bench.sv
module card_cmd_issuer_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0, cmd_ready;
  logic [10:0]  cmd_word = '0;
  logic [31:0]  cmd_arg = '0;
  logic         req_valid, req_ready = 1'b0;
  logic [5:0]   req_index;
  logic [31:0]  req_arg;
  logic         rsp_valid = 1'b0, rsp_ready;
  logic [4:0]   rsp_len = '0;
  logic [127:0] rsp_data = '0;
  logic [10:0]  cmd_q;
  logic [127:0] resp_words;
  logic         sts_cmd_sent, sts_resp_end, sts_timeout, cmd_active;

  always #10 clk = ~clk;

  card_cmd_issuer u_card_cmd_issuer (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word), .cmd_arg(cmd_arg),
    .req_valid(req_valid), .req_ready(req_ready), .req_index(req_index), .req_arg(req_arg),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_len(rsp_len), .rsp_data(rsp_data),
    .cmd_q(cmd_q), .resp_words(resp_words),
    .sts_cmd_sent(sts_cmd_sent), .sts_resp_end(sts_resp_end), .sts_timeout(sts_timeout),
    .cmd_active(cmd_active)
  );

  typedef struct {
    logic [10:0]  cq;
    logic [2:0]   sts;
    logic [127:0] w;
    string        req;
  } exp_t;

  exp_t         sbq[$];
  logic [127:0] model_words = '0;
  int           n_cmp = 0, n_bad = 0;
  bit           done = 1'b0;

  task automatic check_eq(string req, string what, logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_data(logic [7:0] seed);
    logic [127:0] d;
    for (int n = 0; n < 16; n++) d[8*n +: 8] = seed + 8'(n * 29);
    d[120] = 1'b1;
    return d;
  endfunction

  // Expected outcome derived from R4..R8
  task automatic push_expect(logic [10:0] w, logic [4:0] len, logic [127:0] d, string req);
    exp_t e;
    logic [127:0] pk;
    logic want, lng, bad;
    want = w[6];
    lng  = w[7];
    for (int k = 0; k < 4; k++)
      pk[32*k +: 32] = {d[8*(4*k) +: 8], d[8*(4*k+1) +: 8], d[8*(4*k+2) +: 8], d[8*(4*k+3) +: 8]};
    bad = (len == 0) || (len == 4 && lng) || (len != 4 && len != 16);
    e.cq  = w & ~11'h400;
    e.req = req;
    if (!want) e.sts = 3'b001;
    else if (bad) e.sts = 3'b100;
    else begin
      e.sts = 3'b010;
      if (!lng) pk[127:32] = '0;
      else      pk[96] = 1'b0;
      model_words = pk;
    end
    e.w = model_words;
    sbq.push_back(e);
  endtask

  // Monitor: compare at completion (cmd_active falls)
  logic prev_active = 1'b0;
  always @(negedge clk) begin
    if (prev_active && !cmd_active) begin
      if (sbq.size() == 0) check_eq("R10", "unexpected completion", 1, 0);
      else begin
        exp_t e;
        e = sbq.pop_front();
        check_eq({e.req, "/R9"}, "stored word", cmd_q, e.cq);
        check_eq({e.req, "/R11"}, "flags {timeout,resp_end,sent}",
                 {sts_timeout, sts_resp_end, sts_cmd_sent}, e.sts);
        check_eq({e.req, "/R5"}, "response words", resp_words, e.w);
      end
    end
    prev_active = cmd_active;
  end

  task automatic issue(logic [10:0] w, logic [31:0] a, logic [4:0] len,
                       logic [127:0] d, int dly, string req);
    logic [2:0]   sts_before;
    logic [127:0] words_before;
    if (w[10]) push_expect(w, len, d, req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = w; cmd_arg = a;
    while (!cmd_ready) @(negedge clk);
    sts_before   = {sts_timeout, sts_resp_end, sts_cmd_sent};
    words_before = resp_words;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!w[10]) begin
      check_eq("R2", "busy after no-go write", cmd_active, 0);
      check_eq("R2", "request after no-go write", req_valid, 0);
      check_eq("R2", "flags after no-go write", {sts_timeout, sts_resp_end, sts_cmd_sent}, sts_before);
      check_eq("R2", "words after no-go write", resp_words, words_before);
      check_eq("R1", "stored word", cmd_q, w);
      return;
    end
    check_eq("R10", "busy after accept", cmd_active, 1);
    check_eq("R11", "flags cleared on accept", {sts_timeout, sts_resp_end, sts_cmd_sent}, 0);
    for (int i = 0; i < dly; i++) begin
      check_eq("R3", "request held", req_valid, 1);
      @(negedge clk);
    end
    check_eq("R3", "request valid", req_valid, 1);
    check_eq("R3", "request index", req_index, w[5:0]);
    check_eq("R3", "request argument", req_arg, a);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    rsp_valid = 1'b1; rsp_len = len; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R10", "reset ready", cmd_ready, 1);
    check_eq("R10", "reset busy", cmd_active, 0);
    check_eq("R11", "reset flags", {sts_timeout, sts_resp_end, sts_cmd_sent}, 0);
    check_eq("R5", "reset words", resp_words, 0);
    check_eq("R1", "reset word", cmd_q, 0);

    issue(11'h400 | 11'd3,  32'h1111_0000, 5'd0,  mk_data(8'h10), 0, "R8");
    issue(11'h440 | 11'd9,  32'hA5A5_0001, 5'd4,  mk_data(8'h20), 2, "R6");
    issue(11'h4C0 | 11'd2,  32'h0000_00FF, 5'd16, mk_data(8'h31), 1, "R7");
    issue(11'h440 | 11'd5,  32'h1234_5678, 5'd0,  mk_data(8'h40), 3, "R4");
    issue(11'h4C0 | 11'd6,  32'h8765_4321, 5'd4,  mk_data(8'h50), 0, "R4");
    issue(11'h440 | 11'd7,  32'h0BAD_F00D, 5'd7,  mk_data(8'h60), 1, "R4");
    issue(11'h440 | 11'd8,  32'hCAFE_0008, 5'd16, mk_data(8'h70), 0, "R6");
    issue(11'h0C0 | 11'd11, 32'hDEAD_BEEF, 5'd16, mk_data(8'h80), 0, "R2");
    issue(11'h7C0 | 11'd12, 32'h0000_000C, 5'd16, mk_data(8'h93), 2, "R1");
    issue(11'h400 | 11'd13, 32'h0000_000D, 5'd16, mk_data(8'hA0), 0, "R8");

    fork
      issue(11'h440 | 11'd14, 32'h0000_000E, 5'd4,  mk_data(8'hB0), 4, "R10");
      begin
        repeat (3) @(negedge clk);
        issue(11'h4C0 | 11'd15, 32'h0000_000F, 5'd16, mk_data(8'hC1), 1, "R11");
      end
    join

    repeat (4) @(negedge clk);
    check_eq("R10", "scoreboard drained", sbq.size(), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule